// File: doc/BRIEF.md
# Two-Wire Bus Master Byte Engine

This block is the byte-level worker of a two-wire serial bus master. It accepts one command at a time: write a byte, read a byte and acknowledge it, or read a byte and decline it. It then clocks the nine bit periods of that byte onto an open-drain bus. Both bus lines are modelled as an output enable that pulls the line low, plus an input that returns the line level. Start, stop and repeated-start conditions are produced elsewhere. This engine only runs the byte and its acknowledge slot, and between bytes it leaves SCL pulled low and SDA released.

Commands arrive on a valid/ready port. A command is taken in the cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from the next cycle until the byte has finished, so a requester holding `cmd_valid` while the engine is busy is simply not served until the engine is idle again. The result port has no back-pressure. `rsp_done` pulses for one cycle, and `rsp_rdata` and `rsp_ack` hold their values until the next `rsp_done`.

After a written byte, the engine checks the acknowledge slot by polling SDA once per system clock while SCL is seen high. The slot ends as soon as SDA is low, or after a bounded number of polls. After a read byte, the engine drives its own acknowledge (SDA low) or not-acknowledge (SDA released), as the command asks.

Top module: `i2c_byte_master`

## Requirements
- R1: During and right after reset, `scl_oe`=0, `sda_oe`=0, `cmd_ready`=1, `rsp_done`=0, `rsp_rdata`=0 and `rsp_ack`=0.
- R2: A command is taken only when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from the next cycle until `rsp_done`. A `cmd_valid` raised and dropped while busy starts no transfer, and exactly one `rsp_done` follows each taken command.
- R3: `cmd_op`=2'b00 writes `cmd_wdata` MSB first. For each data bit, `sda_oe`=1 (line low) for a 0 and `sda_oe`=0 for a 1. `rsp_rdata` returns the eight levels seen on SDA at the sampling points.
- R4: `sda_oe` only changes when SCL was pulled low (`scl_oe`=1) in the previous cycle, never while SCL is released.
- R5: Every byte produces exactly nine SCL high pulses: eight data bits and one acknowledge slot.
- R6: In a write, SDA seen low during the acknowledge slot gives `rsp_ack`=1 and ends the slot early, even when the slave pulls low several clocks after SCL rises.
- R7: In a write, if SDA stays high for `ACK_POLLS` polls, `rsp_ack`=0. That slot's SCL high phase then lasts `ACK_POLLS`+2 clocks: the two-flop synchronizer delay plus the polls.
- R8: In a read, `sda_oe` is 0 during all eight data bits, and the first bit received ends up in `rsp_rdata[7]`.
- R9: A read with `cmd_op`=2'b01 drives SDA low in the acknowledge slot. A read with 2'b10 or 2'b11 leaves SDA released there. For reads, `rsp_ack` is 1 exactly when SDA was seen low in that slot.
- R10: `rsp_done` is high for exactly one clock, and `rsp_rdata`/`rsp_ack` only change in the cycle where `rsp_done` rises.
- R11: Inside a byte, each SCL low phase lasts `HALF_CYC` clocks. Each data-bit high phase lasts `HALF_CYC` clocks counted from SCL being seen high (`HALF_CYC`+2 with no stretching). After `rsp_done`, SCL stays pulled low and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | 00 write, 01 read+ACK, 10/11 read+NACK |
| cmd_wdata | input | 8 | Byte to write |
| rsp_done | output | 1 | One-cycle end-of-byte pulse |
| rsp_rdata | output | 8 | Byte seen on SDA |
| rsp_ack | output | 1 | SDA seen low in acknowledge slot |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | SDA line level |

## Verification
Writes are tried with all-zero and all-one bytes and with random bytes. Comparing the byte captured by a bus-side slave model against the command tells apart bit-order faults from polarity faults. The acknowledge slot is tried with an immediate acknowledge, a late acknowledge and no acknowledge at all. These separate the early-exit path from the timeout path, and the measured slot length shows whether the poll bound is honoured. Reads with each of the three read codes show whether the engine's own acknowledge follows the command. A command raised and withdrawn while busy shows whether back-pressure really blocks it.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } phase_e;

  localparam logic [1:0] OP_WRITE  = 2'b00;
  localparam logic [1:0] OP_RD_ACK = 2'b01;

  localparam int unsigned BITS_PER_BYTE = 8;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cm_tick_counter.sv
module i2cm_tick_counter #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  assign hit = en && !clr && (cnt == limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= hit ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/i2cm_shreg.sv
module i2cm_shreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], sin};
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int unsigned HALF_CYC    = 625,
  parameter int unsigned ACK_POLLS   = 255,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_wdata,
  output logic       rsp_done,
  output logic [7:0] rsp_rdata,
  output logic       rsp_ack,
  output logic       scl_oe,
  input  logic       scl_in,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam int unsigned MAXCNT = (HALF_CYC > ACK_POLLS) ? HALF_CYC : ACK_POLLS;
  localparam int unsigned CW     = $clog2(MAXCNT + 1);
  localparam int unsigned BW     = $clog2(BITS_PER_BYTE + 1);
  localparam logic [BW-1:0] ACK_SLOT = BW'(BITS_PER_BYTE);

  phase_e          st;
  logic [BW-1:0]   bit_idx;
  logic            is_rd;
  logic            ack_drv;
  logic            scl_hold;
  logic            low_first;
  logic            sda_q;
  logic            ack_q;
  logic            done_q;
  logic [7:0]      rdata_q;
  logic            ack_out_q;

  logic            scl_s, sda_s;
  logic            accept;
  logic            in_ack_slot;
  logic            polling;
  logic            early_ack;
  logic            cnt_clr, cnt_en, cnt_hit;
  logic [CW-1:0]   cnt_limit;
  logic            sh_shift;
  logic [7:0]      sh_q;
  logic            next_drive;

  i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s)
  );
  i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
  );

  assign accept      = cmd_valid && (st == ST_IDLE);
  assign in_ack_slot = (bit_idx == ACK_SLOT);
  assign polling     = (st == ST_HIGH) && in_ack_slot && !is_rd;
  assign early_ack   = polling && scl_s && !sda_s;

  always_comb begin
    unique case (st)
      ST_SETUP, ST_LOW, ST_TAIL: cnt_en = 1'b1;
      ST_HIGH:                   cnt_en = scl_s;
      default:                   cnt_en = 1'b0;
    endcase
  end

  assign cnt_clr   = (st == ST_IDLE) || early_ack;
  assign cnt_limit = polling ? CW'(ACK_POLLS) : CW'(HALF_CYC);

  i2cm_tick_counter #(.W(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
    .limit(cnt_limit), .hit(cnt_hit)
  );

  assign sh_shift = (st == ST_HIGH) && !in_ack_slot && cnt_hit;

  i2cm_shreg #(.W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(cmd_wdata),
    .shift(sh_shift), .sin(sda_s), .q(sh_q)
  );

  always_comb begin
    if (in_ack_slot) next_drive = is_rd && ack_drv;
    else             next_drive = !is_rd && !sh_q[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bit_idx   <= '0;
      is_rd     <= 1'b0;
      ack_drv   <= 1'b0;
      scl_hold  <= 1'b0;
      low_first <= 1'b0;
      sda_q     <= 1'b0;
      ack_q     <= 1'b0;
      done_q    <= 1'b0;
      rdata_q   <= '0;
      ack_out_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            st       <= ST_SETUP;
            is_rd    <= (cmd_op != OP_WRITE);
            ack_drv  <= (cmd_op == OP_RD_ACK);
            scl_hold <= 1'b1;
            sda_q    <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (cnt_hit) begin
            st        <= ST_LOW;
            bit_idx   <= '0;
            low_first <= 1'b1;
          end
        end
        ST_LOW: begin
          if (low_first) begin
            sda_q     <= next_drive;
            low_first <= 1'b0;
          end
          if (cnt_hit) st <= ST_HIGH;
        end
        ST_HIGH: begin
          if (!in_ack_slot) begin
            if (cnt_hit) begin
              st        <= ST_LOW;
              bit_idx   <= bit_idx + BW'(1);
              low_first <= 1'b1;
            end
          end else if (is_rd) begin
            if (cnt_hit) begin
              ack_q <= !sda_s;
              st    <= ST_TAIL;
            end
          end else if (early_ack) begin
            ack_q <= 1'b1;
            st    <= ST_TAIL;
          end else if (cnt_hit) begin
            ack_q <= 1'b0;
            st    <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (cnt_hit) begin
            st        <= ST_IDLE;
            sda_q     <= 1'b0;
            done_q    <= 1'b1;
            rdata_q   <= sh_q;
            ack_out_q <= ack_q;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == ST_IDLE);
  assign scl_oe    = scl_hold && (st != ST_HIGH);
  assign sda_oe    = sda_q;
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;
  assign rsp_ack   = ack_out_q;
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       rsp_done,
  input logic [7:0] rsp_rdata,
  input logic       rsp_ack,
  input logic       scl_oe,
  input logic       sda_oe
);
  p_sda_moves_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(scl_oe) |-> $stable(sda_oe));

  p_take_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> cmd_ready);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_done |-> ($stable(rsp_rdata) && $stable(rsp_ack)));

  p_park_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (scl_oe && !sda_oe));
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_ack(rsp_ack),
  .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_byte_master_bench.sv
`timescale 1ns/1ps
module i2c_byte_master_bench;
  localparam int HALF  = 4;
  localparam int POLLS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_wdata = 8'h00;
  logic       rsp_done;
  logic [7:0] rsp_rdata;
  logic       rsp_ack;
  logic       scl_oe, sda_oe;
  logic       slave_low = 1'b0;
  wire        scl_line = !scl_oe;
  wire        sda_line = !(sda_oe || slave_low);

  always #4 clk = ~clk;

  i2c_byte_master #(.HALF_CYC(HALF), .ACK_POLLS(POLLS), .SYNC_STAGES(2)) u_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .rsp_ack(rsp_ack), .scl_oe(scl_oe),
    .scl_in(scl_line), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model state
  int       s_pulses = 0;
  logic [7:0] s_cap = 8'h00;
  bit       s_read = 1'b0;
  logic [7:0] s_tx = 8'h00;
  bit       s_ack = 1'b0;
  int       s_delay = 0;
  bit       m_ack_oe = 1'b0;
  bit       m_data_oe_any = 1'b0;
  int       exp_hi9 = -1;
  int       done_cnt = 0;

  initial forever begin
    @(posedge scl_line);
    s_pulses++;
    if (s_pulses <= 8) begin
      s_cap = {s_cap[6:0], sda_line};
      if (s_read && sda_oe) m_data_oe_any = 1'b1;
    end else if (s_pulses == 9) begin
      m_ack_oe = sda_oe;
      if (!s_read && s_ack) begin
        repeat (s_delay) @(posedge clk);
        #1 slave_low = 1'b1;
      end
    end
  end

  initial forever begin
    @(negedge scl_line);
    if (s_read && s_pulses < 8) slave_low = ~s_tx[3'(7 - s_pulses)];
    else                        slave_low = 1'b0;
  end

  // bus timing monitor
  initial begin
    bit prev_scl = 1'b0;
    bit prev_sda = 1'b0;
    int lo_run = 0;
    int hi_run = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (rsp_done) done_cnt++;
        if (sda_oe != prev_sda && !prev_scl)
          check(1'b0, "R4 sda_oe moved while SCL released", sda_oe, prev_sda);
        if (scl_oe && !prev_scl) begin
          if (s_pulses >= 1 && s_pulses <= 8)
            check(hi_run == HALF + 2, "R11 data high phase", hi_run, HALF + 2);
          else if (s_pulses == 9 && exp_hi9 > 0)
            check(hi_run == exp_hi9, "R7 ack slot high phase", hi_run, exp_hi9);
          lo_run = 1;
        end else if (!scl_oe && prev_scl) begin
          if (s_pulses >= 2 && s_pulses <= 9)
            check(lo_run == HALF, "R11 low phase", lo_run, HALF);
          hi_run = 1;
        end else begin
          if (scl_oe) lo_run++;
          else        hi_run++;
        end
      end
      prev_scl = scl_oe;
      prev_sda = sda_oe;
    end
  end

  function automatic bit exp_read_ack(input logic [1:0] op);
    return op == 2'b01;
  endfunction

  task automatic do_xfer(input logic [1:0] op, input logic [7:0] data,
                         input bit sack, input int delay, input bit poke);
    int waited;
    int d0;
    logic [7:0] held_d;
    bit held_a;
    bit rd;
    rd = (op != 2'b00);
    @(negedge clk);
    s_pulses = 0; s_cap = 8'h00; s_read = rd; s_tx = data;
    s_ack = sack; s_delay = delay; m_ack_oe = 1'b0; m_data_oe_any = 1'b0;
    exp_hi9 = rd ? HALF + 2 : (sack ? -1 : POLLS + 2);
    if (rd) slave_low = ~data[7];
    else    slave_low = 1'b0;
    d0 = done_cnt;
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = data;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R2 busy after take", cmd_ready, 0);
    if (poke) begin
      repeat (10) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b00; cmd_wdata = ~data;
      repeat (5) begin
        @(negedge clk);
        check(cmd_ready == 1'b0, "R2 ready low while busy", cmd_ready, 0);
      end
      cmd_valid = 1'b0;
    end
    waited = 0;
    while (!rsp_done && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    check(rsp_done == 1'b1, "R10 done seen", rsp_done, 1);
    check(s_pulses == 9, "R5 nine pulses", s_pulses, 9);
    if (!rd) begin
      check(s_cap == data, "R3 slave captured byte", s_cap, data);
      check(rsp_rdata == data, "R3 echo byte", rsp_rdata, data);
      check(rsp_ack == sack, sack ? "R6 ack seen" : "R7 no ack", rsp_ack, sack);
    end else begin
      check(m_data_oe_any == 1'b0, "R8 SDA released on data", m_data_oe_any, 0);
      check(rsp_rdata == data, "R8 read byte MSB first", rsp_rdata, data);
      check(m_ack_oe == exp_read_ack(op), "R9 master ack drive", m_ack_oe, exp_read_ack(op));
      check(rsp_ack == exp_read_ack(op), "R9 read ack flag", rsp_ack, exp_read_ack(op));
    end
    held_d = rsp_rdata; held_a = rsp_ack;
    @(negedge clk);
    check(rsp_done == 1'b0, "R10 one-cycle done", rsp_done, 0);
    repeat (6) @(negedge clk);
    check(rsp_rdata == held_d && rsp_ack == held_a, "R10 result held", rsp_rdata, held_d);
    check(scl_oe == 1'b1 && sda_oe == 1'b0, "R11 bus parked", {scl_oe, sda_oe}, 2);
    check(cmd_ready == 1'b1 && s_pulses == 9, "R2 no extra transfer", s_pulses, 9);
    check(done_cnt == d0 + 1, "R2 single done", done_cnt - d0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    check(scl_oe == 0 && sda_oe == 0, "R1 bus released in reset", {scl_oe, sda_oe}, 0);
    check(cmd_ready == 1 && rsp_done == 0, "R1 ready in reset", {cmd_ready, rsp_done}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_rdata == 0 && rsp_ack == 0, "R1 result cleared", {rsp_ack, rsp_rdata}, 0);
    check(scl_oe == 0 && sda_oe == 0, "R1 bus released after reset", {scl_oe, sda_oe}, 0);

    do_xfer(2'b00, 8'h00, 1'b1, 0, 1'b0);
    do_xfer(2'b00, 8'hFF, 1'b1, 0, 1'b0);
    do_xfer(2'b00, 8'h96, 1'b0, 0, 1'b0);
    do_xfer(2'b00, 8'h4B, 1'b1, 8, 1'b0);
    do_xfer(2'b01, 8'hA5, 1'b0, 0, 1'b0);
    do_xfer(2'b10, 8'h3C, 1'b0, 0, 1'b0);
    do_xfer(2'b11, 8'h81, 1'b0, 0, 1'b0);
    do_xfer(2'b00, 8'hC3, 1'b1, 2, 1'b1);

    for (int i = 0; i < 30; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 2));
      do_xfer(op, 8'($urandom), 1'($urandom), int'($urandom_range(0, 8)), 1'b0);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule